// File: doc/BRIEF.md
# GPIO Port Interrupt Controller

This block watches one bank of general-purpose input pins and raises a single interrupt for the whole bank. Each pin has its own trigger condition: high level, low level, rising edge or falling edge. When a pin's condition is met, a sticky pending bit for that pin is set. A per-pin enable word selects which pending bits may reach the bank interrupt line. A bank-wide enable gates that line.

Software reaches the block through a small 32-bit register bus with one-cycle read latency. Before detection, the pins pass through a two-flop synchronizer. Detection happens only on cycles where a sampling strobe is high. A control bit selects either the fast strobe or the slow strobe. A both-edges trigger is not provided; software gets that effect by flipping a pin between rising and falling after each event.

Top module: `gpio_port_irq`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: The trigger field of pin p is 2 bits wide at bit 2*(p mod 16). Pins 16..31 use the word at byte offset 0x00 and pins 0..15 use the word at 0x04. Both words read back what was written.
- R3: Trigger code 2'b10 (rising) sets pin p's pending bit on a sampled 0-to-1 transition only.
- R4: Trigger code 2'b11 (falling) sets the pending bit on a sampled 1-to-0 transition only. A steady high pin sets nothing.
- R5: Codes 2'b00 (level high) and 2'b01 (level low) set the pending bit on every sample while the level holds, so the bit comes back at once after a clear.
- R6: In the pending word (offset 0x10), writing 1 clears a bit and writing 0 leaves it unchanged. A detected event in the same cycle as a clear keeps the bit set. Only events set pending bits.
- R7: Pending bits latch whatever the mask word (offset 0x08) holds. `irq_o` goes high one cycle after any pending bit whose mask bit is 1.
- R8: Control bit 0 (offset 0x0C) is the bank enable. With it clear, `irq_o` stays low.
- R9: Control bit 1 selects the sampling strobe: 1 selects `fast_stb_i` and 0 selects `slow_stb_i`. No event is detected in a cycle where the selected strobe is low.
- R10: Control bit 2 is the bank pending flag. It is set by an event on a pin whose mask bit is 1, it is not set by events on masked pins, and it is cleared by writing 1.
- R11: `bus_rdata_o` is registered one cycle after `bus_rd_i`. Reads of offsets 0x14..0x1C, or of a non-word-aligned address, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | NPINS | Asynchronous pin levels |
| fast_stb_i | input | 1 | Fast sampling strobe |
| slow_stb_i | input | 1 | Slow sampling strobe |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after bus_rd_i |
| irq_o | output | 1 | Bank interrupt, registered |

## Verification
The bench builds the block with its defaults: 32 pins, which fills both trigger words, and a 5-bit address, which covers every mapped and unmapped word. With all 32 pins present, a sweep can put every trigger code on every pin in turn. It checks that the pending word changes in exactly one bit, which exposes any wrong field placement or swapped word. Holding each strobe low on its own shows that both the strobe selection and the sample gating take effect.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [1:0] {
    TRIG_LVL_HI = 2'b00,
    TRIG_LVL_LO = 2'b01,
    TRIG_RISE   = 2'b10,
    TRIG_FALL   = 2'b11
  } trig_e;

  localparam int FIELDS_PER_WORD = 16;

  // word index = byte offset / 4
  localparam int WIDX_TYPE_UPPER = 0;
  localparam int WIDX_TYPE_LOWER = 1;
  localparam int WIDX_MASK       = 2;
  localparam int WIDX_CTRL       = 3;
  localparam int WIDX_PEND       = 4;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_SEL_BIT  = 1;
  localparam int CTRL_FLAG_BIT = 2;
endpackage

// File: rtl/irq_pin_sampler.sv
module irq_pin_sampler #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pins_i,
  input  logic         stb_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pins_i;
      sync_q <= meta_q;
      if (stb_i) prev_q <= sync_q;
    end
  end

  assign cur_o  = sync_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/irq_trig_detect.sv
module irq_trig_detect
  import gpio_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           stb_i,
  input  logic [W-1:0]   cur_i,
  input  logic [W-1:0]   prev_i,
  input  logic [2*W-1:0] types_i,
  output logic [W-1:0]   evt_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic hit;
    always_comb begin
      unique case (trig_e'(types_i[2*i +: 2]))
        TRIG_LVL_HI: hit = cur_i[i];
        TRIG_LVL_LO: hit = !cur_i[i];
        TRIG_RISE:   hit = cur_i[i] && !prev_i[i];
        TRIG_FALL:   hit = !cur_i[i] && prev_i[i];
        default:     hit = 1'b0;
      endcase
    end
    assign evt_o[i] = stb_i && hit;
  end
endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  pins_i,
  input  logic              fast_stb_i,
  input  logic              slow_stb_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [31:0]        type_upper_q, type_lower_q;
  logic [NPINS-1:0]   mask_q, pend_q, evt;
  logic [NPINS-1:0]   pin_cur, pin_prev;
  logic [2*NPINS-1:0] pin_types;
  logic               ctrl_en_q, ctrl_sel_q, flag_q, irq_q;
  logic               sample_en;
  logic [31:0]        rdata_q, rd_mux;
  logic [WIDX_W-1:0]  widx;
  logic               aligned;

  assign sample_en = ctrl_sel_q ? fast_stb_i : slow_stb_i;
  assign widx      = bus_addr_i[ADDR_W-1:2];
  assign aligned   = (bus_addr_i[1:0] == 2'b00);

  function automatic logic hits(input int idx);
    return aligned && (int'(widx) == idx);
  endfunction

  // lower pins live in the second word, upper pins in the first
  for (genvar i = 0; i < NPINS; i++) begin : g_type
    if (i < FIELDS_PER_WORD) begin : g_lo
      assign pin_types[2*i +: 2] = type_lower_q[2*i +: 2];
    end else begin : g_hi
      assign pin_types[2*i +: 2] = type_upper_q[2*(i-FIELDS_PER_WORD) +: 2];
    end
  end

  irq_pin_sampler #(.W(NPINS)) u_sampler (
    .clk    (clk),
    .rst    (rst),
    .pins_i (pins_i),
    .stb_i  (sample_en),
    .cur_o  (pin_cur),
    .prev_o (pin_prev)
  );

  irq_trig_detect #(.W(NPINS)) u_detect (
    .stb_i   (sample_en),
    .cur_i   (pin_cur),
    .prev_i  (pin_prev),
    .types_i (pin_types),
    .evt_o   (evt)
  );

  logic wr_pend, wr_ctrl;
  logic [NPINS-1:0] clr_bits;
  assign wr_pend  = bus_wr_i && hits(WIDX_PEND);
  assign wr_ctrl  = bus_wr_i && hits(WIDX_CTRL);
  assign clr_bits = wr_pend ? bus_wdata_i[NPINS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      type_upper_q <= '0;
      type_lower_q <= '0;
      mask_q       <= '0;
      ctrl_en_q    <= 1'b0;
      ctrl_sel_q   <= 1'b0;
      flag_q       <= 1'b0;
      pend_q       <= '0;
      irq_q        <= 1'b0;
    end else begin
      if (bus_wr_i && hits(WIDX_TYPE_UPPER)) type_upper_q <= bus_wdata_i;
      if (bus_wr_i && hits(WIDX_TYPE_LOWER)) type_lower_q <= bus_wdata_i;
      if (bus_wr_i && hits(WIDX_MASK))       mask_q <= bus_wdata_i[NPINS-1:0];
      if (wr_ctrl) begin
        ctrl_en_q  <= bus_wdata_i[CTRL_EN_BIT];
        ctrl_sel_q <= bus_wdata_i[CTRL_SEL_BIT];
      end
      // new events win over a same-cycle clear
      pend_q <= (pend_q & ~clr_bits) | evt;
      flag_q <= (flag_q && !(wr_ctrl && bus_wdata_i[CTRL_FLAG_BIT])) || (|(evt & mask_q));
      irq_q  <= ctrl_en_q && (|(pend_q & mask_q));
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hits(WIDX_TYPE_UPPER)) rd_mux = type_upper_q;
    if (hits(WIDX_TYPE_LOWER)) rd_mux = type_lower_q;
    if (hits(WIDX_MASK))       rd_mux = 32'(mask_q);
    if (hits(WIDX_CTRL)) begin
      rd_mux[CTRL_EN_BIT]   = ctrl_en_q;
      rd_mux[CTRL_SEL_BIT]  = ctrl_sel_q;
      rd_mux[CTRL_FLAG_BIT] = flag_q;
    end
    if (hits(WIDX_PEND))       rd_mux = 32'(pend_q);
  end

  always_ff @(posedge clk) begin
    if (rst)           rdata_q <= '0;
    else if (bus_rd_i) rdata_q <= rd_mux;
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = irq_q;

  // ---------------- assertions ----------------
  assert_no_evt_off_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    !sample_en |-> (evt == '0));

  assert_pend_set_by_evt_R6: assert property (@(posedge clk) disable iff (rst)
    (|(pend_q & ~$past(pend_q))) |-> $past(|evt));

  assert_pend_clr_by_write_R6: assert property (@(posedge clk) disable iff (rst)
    (|($past(pend_q) & ~pend_q)) |-> $past(wr_pend));

  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(ctrl_en_q));

  assert_flag_from_unmasked_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(|(evt & mask_q)));

  assert_unmapped_reads_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_i && (!aligned || int'(widx) > WIDX_PEND)) |=> (bus_rdata_o == 32'd0));

  for (genvar i = 0; i < NPINS; i++) begin : g_chk
    assert_level_refire_R5: assert property (@(posedge clk) disable iff (rst)
      (sample_en && pin_types[2*i +: 2] == TRIG_LVL_HI && pin_cur[i]) |=> pend_q[i]);
  end
endmodule

// File: tb/tb_gpio_port_irq.sv
module tb_gpio_port_irq;
  localparam int NP = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [NP-1:0] pins = '0;
  logic        fast_stb = 1'b1;
  logic        slow_stb = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_cmp = 0, n_bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  gpio_port_irq dut (
    .clk(clk), .rst(rst), .pins_i(pins),
    .fast_stb_i(fast_stb), .slow_stb_i(slow_stb),
    .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic set_type(input int p, input logic [1:0] code);
    logic [31:0] f;
    f = 32'(code) << (2 * (p % 16));
    if (p < 16) begin wr(5'h04, f); wr(5'h00, 32'h0); end
    else        begin wr(5'h00, f); wr(5'h04, 32'h0); end
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(5'(a * 4), v);
      check("R1 reset reg", v, 32'h0);
    end
    check("R1 irq at reset", 32'(irq), 32'h0);

    // R2 readback of both type words
    wr(5'h00, 32'h1234_5678);
    wr(5'h04, 32'h9abc_def0);
    rd(5'h00, v); check("R2 upper type word", v, 32'h1234_5678);
    rd(5'h04, v); check("R2 lower type word", v, 32'h9abc_def0);
    wr(5'h00, 32'h0); wr(5'h04, 32'h0);

    wr(5'h0C, 32'h3);   // enable, fast strobe
    wr(5'h10, 32'hffff_ffff);

    // R2/R3/R4/R5 sweep over every pin and trigger code
    for (int p = 0; p < NP; p++) begin
      logic [31:0] bit_p;
      bit_p = 32'h1 << p;
      set_type(p, 2'b10);
      wr(5'h10, 32'hffff_ffff);
      @(negedge clk); pins[p] = 1'b1;
      settle(); rd(5'h10, v); check("R3 rising sets only its bit", v, bit_p);

      set_type(p, 2'b11);
      wr(5'h10, 32'hffff_ffff);
      settle(); rd(5'h10, v); check("R4 steady high no falling event", v, 32'h0);
      @(negedge clk); pins[p] = 1'b0;
      settle(); rd(5'h10, v); check("R4 falling sets only its bit", v, bit_p);

      set_type(p, 2'b01);
      wr(5'h10, 32'hffff_ffff);
      settle(); rd(5'h10, v); check("R5 level low refires after clear", v, bit_p);

      set_type(p, 2'b00);
      wr(5'h10, 32'hffff_ffff);
      settle(); rd(5'h10, v); check("R5 level high quiet while low", v, 32'h0);
    end

    // R7 mask gating; pin 3 rising while masked
    wr(5'h04, 32'h2 << 6);
    @(negedge clk); pins[3] = 1'b1;
    settle();
    rd(5'h10, v); check("R7 pending latches while masked", v, 32'h8);
    check("R7 irq low when masked", 32'(irq), 32'h0);
    rd(5'h0C, v); check("R10 masked event leaves flag clear", v, 32'h3);
    wr(5'h08, 32'h8);
    @(negedge clk);
    check("R7 irq high when unmasked", 32'(irq), 32'h1);
    wr(5'h08, 32'h10);
    @(negedge clk);
    check("R7 irq low with other bit masked in", 32'(irq), 32'h0);

    // R10 port flag from unmasked pin 4
    wr(5'h04, (32'h2 << 6) | (32'h2 << 8));
    @(negedge clk); pins[4] = 1'b1;
    settle();
    rd(5'h0C, v); check("R10 flag set by unmasked event", v, 32'h7);
    wr(5'h0C, 32'h7);
    rd(5'h0C, v); check("R10 flag write-one clear", v, 32'h3);

    // R8 enable gates irq
    @(negedge clk);
    check("R8 irq high when enabled", 32'(irq), 32'h1);
    wr(5'h0C, 32'h2);
    @(negedge clk);
    check("R8 irq low when disabled", 32'(irq), 32'h0);
    wr(5'h0C, 32'h3);

    // R6 write-one-clear semantics
    rd(5'h10, v); check("R6 pending before clears", v, 32'h18);
    wr(5'h10, 32'h0);
    rd(5'h10, v); check("R6 writing zero keeps bits", v, 32'h18);
    wr(5'h10, 32'h8);
    rd(5'h10, v); check("R6 single bit cleared", v, 32'h10);
    wr(5'h10, 32'hffff_ffff);
    rd(5'h10, v); check("R6 all cleared", v, 32'h0);
    @(negedge clk);
    check("R6 irq drops after clear", 32'(irq), 32'h0);

    // R9 strobe selection: slow strobe
    @(negedge clk); pins[3] = 1'b0; pins[4] = 1'b0;
    wr(5'h04, (32'h2 << 14) | (32'h2 << 16));
    wr(5'h0C, 32'h1);
    wr(5'h10, 32'hffff_ffff);
    @(negedge clk); pins[7] = 1'b1;
    settle(); rd(5'h10, v); check("R9 no detect without slow strobe", v, 32'h0);
    @(negedge clk); slow_stb = 1'b1;
    @(negedge clk); slow_stb = 1'b0;
    rd(5'h10, v); check("R9 slow strobe detects edge", v, 32'h80);

    // R9 fast strobe selected but held low
    wr(5'h0C, 32'h3);
    fast_stb = 1'b0;
    wr(5'h10, 32'hffff_ffff);
    @(negedge clk); pins[8] = 1'b1;
    settle();
    @(negedge clk); slow_stb = 1'b1;
    @(negedge clk); slow_stb = 1'b0;
    rd(5'h10, v); check("R9 unselected strobe ignored", v, 32'h0);
    fast_stb = 1'b1;
    settle(); rd(5'h10, v); check("R9 fast strobe detects edge", v, 32'h100);

    // R5 level high refire on pins 7 and 8
    wr(5'h04, 32'h0);
    wr(5'h10, 32'hffff_ffff);
    rd(5'h10, v); check("R5 level high refires after clear", v, 32'h180);

    // R11 unmapped and misaligned reads
    rd(5'h14, v); check("R11 unmapped 0x14", v, 32'h0);
    rd(5'h18, v); check("R11 unmapped 0x18", v, 32'h0);
    rd(5'h1C, v); check("R11 unmapped 0x1C", v, 32'h0);
    rd(5'h11, v); check("R11 misaligned read", v, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule